// File: doc/BRIEF.md
# Atomic Unsigned-Minimum Execution Unit

This unit runs one read-modify-write instruction at a time. It takes a 32-bit instruction word and decodes it. It reads a base address and an operand through register-file read ports. Under a memory lock it loads a value from memory and stores back the smaller of that value and the operand, compared as unsigned numbers. It then hands the value from before the update to the register file as a write to the destination register.

A size bit selects 32-bit or 64-bit data. Register index 31 means something different in each field. As the operand, it reads as zero. As the base, it selects the stack pointer. As the destination, it discards the result. A misaligned base raises a fault before any memory access. An instruction word that does not match the pattern is rejected. Neither case touches memory or the register file.

The instruction input is a valid/ready stream. `instr_ready` is high only while the unit is idle, and a word is taken on a clock edge where valid and ready are both high. A word offered while the unit is busy simply waits, so the source must hold it steady. Memory reads and writes each use a request held until acknowledge. The completion, fault and reject outputs are single-cycle pulses with no back-pressure.

Top module: `amin_exec_unit`

## Requirements
- R1: An instruction is accepted only when all of these bits match: bit 31=1, bits [29:27]=111, bit 26=0, bits [25:22]=0000, bit 21=1, bit 15=0, bits [14:12]=111 and bits [11:10]=00. Any other word gives a one-cycle `reject` pulse in the cycle after acceptance, with no memory request and no `done`.
- R2: The operand register index is bits [20:16], the base index is bits [9:5] and the destination index is bits [4:0]. An operand index of 31 supplies the value zero.
- R3: Bit 30 selects the size: 0 for 32-bit, 1 for 64-bit, and `mem_dword` shows it. In 32-bit mode only bits [31:0] of `mem_rdata` and of the operand take part.
- R4: The value written to memory is the unsigned minimum of the loaded value and the operand at the access size, written to the base address.
- R5: `rd_data` carries the loaded value from before the update. In 32-bit mode it is zero-extended to 64 bits.
- R6: A destination index of 31 gives `done` with `rd_we` low. Otherwise `rd_we` is high with `done`, and `rd_idx` holds the destination index.
- R7: A base index of 31 takes the base from `sp_val`. If any of the stack pointer's low four bits is set, a one-cycle `fault` pulse follows and no memory request is made.
- R8: A base from a general register must be aligned to the access size: low 2 bits zero for 32-bit, low 3 bits zero for 64-bit. Otherwise the unit faults as in R7.
- R9: `mem_lock` is high whenever `mem_req` is high. It stays high without a break from the read request until the write acknowledge. Exactly one read and one write are made per instruction, and the write happens even when the stored value equals the loaded value.
- R10: `instr_ready` is high only in the idle state. `done` is a single-cycle pulse after the write acknowledge, and the unit is ready again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle, will take a word |
| instr | input | 32 | Instruction word |
| rs_idx | output | 5 | Operand register read index |
| rs_val | input | 64 | Operand register value |
| rn_idx | output | 5 | Base register read index |
| rn_val | input | 64 | Base register value |
| sp_val | input | 64 | Stack pointer value |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Locks memory for the read-modify-write |
| mem_dword | output | 1 | 1: 64-bit access, 0: 32-bit |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Read data, valid with ack |
| done | output | 1 | Instruction complete (pulse) |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 64 | Value loaded before the update |
| fault | output | 1 | Alignment fault (pulse) |
| reject | output | 1 | Unmatched instruction (pulse) |

## Verification
The hardest case to reach is a stack-pointer base that is aligned for a 64-bit access but not to 16 bytes. It passes any size-based check, so only the stack-pointer rule catches it. The bench sets `sp_val` to such values and also to base addresses offset by 2 or 4 bytes. A second subtle case is 32-bit mode with nonzero upper memory bits. The bench memory fills untouched locations with nonzero upper halves, so any leak of those bits shows up in the minimum or in the zero-extended result. Acknowledge delays are randomised so that the lock is seen to hold across stretched read and write phases.

// File: rtl/amin_pkg.sv
package amin_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_READ, S_COMPUTE, S_WRITE, S_WRBACK, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic             hit;
    logic             dword;
    logic [IDX_W-1:0] rs;
    logic [IDX_W-1:0] rn;
    logic [IDX_W-1:0] rt;
  } dec_t;
endpackage

// File: rtl/amin_decode.sv
module amin_decode
  import amin_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.hit   = instr[31] && (instr[29:27] == 3'b111) && !instr[26] &&
                (instr[25:22] == 4'b0000) && instr[21] && !instr[15] &&
                (instr[14:12] == 3'b111) && (instr[11:10] == 2'b00);
    dec.dword = instr[30];
    dec.rs    = instr[20:16];
    dec.rn    = instr[9:5];
    dec.rt    = instr[4:0];
  end
endmodule

// File: rtl/amin_minval.sv
module amin_minval #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              dword,
  output logic [DATA_W-1:0] lo
);
  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0] lo_half;

  always_comb begin
    lo_half = (a[HALF-1:0] < b[HALF-1:0]) ? a[HALF-1:0] : b[HALF-1:0];
    if (dword) lo = (a < b) ? a : b;
    else       lo = {{HALF{1'b0}}, lo_half};
  end
endmodule

// File: rtl/amin_seq.sv
module amin_seq
  import amin_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr,
  output logic [INSTR_W-1:0] instr_q,
  input  dec_t               dec,
  output logic [IDX_W-1:0]   rs_idx,
  input  logic [DATA_W-1:0]  rs_val,
  output logic [IDX_W-1:0]   rn_idx,
  input  logic [ADDR_W-1:0]  rn_val,
  input  logic [ADDR_W-1:0]  sp_val,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_lock,
  output logic               mem_dword,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [DATA_W-1:0]  loaded_q,
  output logic [DATA_W-1:0]  opnd_q,
  input  logic [DATA_W-1:0]  min_val,
  output logic               done,
  output logic               rd_we,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               fault,
  output logic               reject
);
  localparam int HALF    = DATA_W / 2;
  localparam int W_LSB   = $clog2(HALF / 8);
  localparam int DW_LSB  = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0]  IDX_SPECIAL = '1;
  localparam logic [ADDR_W-1:0] W_MASK  = {{(ADDR_W-W_LSB){1'b0}}, {W_LSB{1'b1}}};
  localparam logic [ADDR_W-1:0] DW_MASK = {{(ADDR_W-DW_LSB){1'b0}}, {DW_LSB{1'b1}}};
  localparam logic [ADDR_W-1:0] SP_MASK = {{(ADDR_W-SP_ALIGN_BITS){1'b0}}, {SP_ALIGN_BITS{1'b1}}};

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_sel;
  logic [DATA_W-1:0] newv_q, opnd_sel;
  logic              misalign;

  function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic dw);
    return dw ? v : {{HALF{1'b0}}, v[HALF-1:0]};
  endfunction

  always_comb begin
    base_sel = (dec.rn == IDX_SPECIAL) ? sp_val : rn_val;
    opnd_sel = (dec.rs == IDX_SPECIAL) ? '0 : rs_val;
    if (dec.rn == IDX_SPECIAL) misalign = |(base_sel & SP_MASK);
    else                       misalign = |(base_sel & (dec.dword ? DW_MASK : W_MASK));
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (instr_valid) state_d = S_DECODE;
      S_DECODE:  state_d = (!dec.hit || misalign) ? S_IDLE : S_READ;
      S_READ:    if (mem_ack) state_d = S_COMPUTE;
      S_COMPUTE: state_d = S_WRITE;
      S_WRITE:   if (mem_ack) state_d = S_WRBACK;
      S_WRBACK:  state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      instr_q  <= '0;
      base_q   <= '0;
      opnd_q   <= '0;
      loaded_q <= '0;
      newv_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && instr_valid) instr_q <= instr;
      if (state_q == S_DECODE) begin
        base_q <= base_sel;
        opnd_q <= fit(opnd_sel, dec.dword);
      end
      if (state_q == S_READ && mem_ack) loaded_q <= fit(mem_rdata, dec.dword);
      if (state_q == S_COMPUTE) newv_q <= min_val;
    end
  end

  assign instr_ready = (state_q == S_IDLE);
  assign rs_idx      = dec.rs;
  assign rn_idx      = dec.rn;
  assign mem_req     = (state_q == S_READ) || (state_q == S_WRITE);
  assign mem_we      = (state_q == S_WRITE);
  assign mem_lock    = (state_q == S_READ) || (state_q == S_COMPUTE) || (state_q == S_WRITE);
  assign mem_dword   = dec.dword;
  assign mem_addr    = base_q;
  assign mem_wdata   = newv_q;
  assign done        = (state_q == S_DONE);
  assign rd_we       = done && (dec.rt != IDX_SPECIAL);
  assign rd_idx      = dec.rt;
  assign rd_data     = loaded_q;
  assign fault       = (state_q == S_DECODE) && dec.hit && misalign;
  assign reject      = (state_q == S_DECODE) && !dec.hit;

  // R9: every request is made under the lock
  p_req_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  // R9: lock is released only after a write acknowledge
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && !(mem_we && mem_ack)) |=> mem_lock);
  // R4: stored value never exceeds either input
  p_wdata_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata <= loaded_q && mem_wdata <= opnd_q));
  // R10: completion lasts one cycle and the unit is ready afterwards
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && instr_ready));
  // R7: a fault leaves memory untouched
  p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!mem_req && instr_ready));
  // R6: no write to index 31
  p_rd_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_idx != IDX_SPECIAL));
  // R5: 32-bit result carries zero upper half
  p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mem_dword) |-> (rd_data[DATA_W-1:HALF] == '0));
endmodule

// File: rtl/amin_exec_unit.sv
module amin_exec_unit
  import amin_pkg::*;
#(
  parameter int DATA_W        = 64,
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [INSTR_W-1:0] instr,
  output logic [IDX_W-1:0]   rs_idx,
  input  logic [DATA_W-1:0]  rs_val,
  output logic [IDX_W-1:0]   rn_idx,
  input  logic [ADDR_W-1:0]  rn_val,
  input  logic [ADDR_W-1:0]  sp_val,
  output logic               mem_req,
  output logic               mem_we,
  output logic               mem_lock,
  output logic               mem_dword,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done,
  output logic               rd_we,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               fault,
  output logic               reject
);
  logic [INSTR_W-1:0] instr_q;
  dec_t               dec;
  logic [DATA_W-1:0]  loaded_q, opnd_q, min_val;

  amin_decode u_dec (.instr(instr_q), .dec(dec));

  amin_minval #(.DATA_W(DATA_W)) u_min (
    .a(loaded_q), .b(opnd_q), .dword(dec.dword), .lo(min_val)
  );

  amin_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SP_ALIGN_BITS(SP_ALIGN_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr(instr),
    .instr_q(instr_q), .dec(dec),
    .rs_idx(rs_idx), .rs_val(rs_val), .rn_idx(rn_idx), .rn_val(rn_val), .sp_val(sp_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_dword(mem_dword),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .loaded_q(loaded_q), .opnd_q(opnd_q), .min_val(min_val),
    .done(done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .fault(fault), .reject(reject)
  );
endmodule

// File: tb/amin_exec_unit_test.sv
`timescale 1ns/1ps
module amin_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr = '0;
  logic [4:0]  rs_idx, rn_idx, rd_idx;
  logic [63:0] rs_val, rn_val, sp_val = '0;
  logic        mem_req, mem_we, mem_lock, mem_dword;
  logic [63:0] mem_addr, mem_wdata, rd_data;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done, rd_we, fault, reject;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_rd = 0, n_wr = 0, dly = 0;
  logic [63:0] last_raddr, last_waddr;
  logic        last_rdw;

  logic [63:0] regs [0:31];
  logic [63:0] mem [logic [63:0]];

  always #2.5 clk = ~clk;

  assign rs_val = regs[rs_idx];
  assign rn_val = regs[rn_idx];

  amin_exec_unit uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_mem(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return {~a[31:0] | 32'h1, a[31:0] ^ 32'h5A5A_1234};
  endfunction

  function automatic logic [31:0] enc(input bit dw, input int rs, input int rn, input int rt);
    return {1'b1, dw, 3'b111, 1'b0, 2'b00, 2'b00, 1'b1, 5'(rs), 1'b0, 3'b111, 2'b00, 5'(rn), 5'(rt)};
  endfunction

  // memory responder and per-clock lock comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_req) check(mem_lock, "R9 lock during request", 64'(mem_lock), 64'd1);
      if (n_rd == 1 && n_wr == 0) check(mem_lock, "R9 lock between read and write", 64'(mem_lock), 64'd1);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (dly != 0) dly--;
        else begin
          if (mem_we) begin
            logic [63:0] cur;
            cur = rd_mem(mem_addr);
            mem[mem_addr] = mem_dword ? mem_wdata : {cur[63:32], mem_wdata[31:0]};
            last_waddr = mem_addr;
            n_wr++;
          end else begin
            mem_rdata = rd_mem(mem_addr);
            last_raddr = mem_addr;
            last_rdw = mem_dword;
            n_rd++;
          end
          mem_ack = 1'b1;
          dly = $urandom_range(0, 2);
        end
      end
    end
  end

  // kind: 0 complete, 1 fault, 2 reject
  task automatic run_op(input logic [31:0] ins);
    bit hit, dw;
    int rs, rn, rt, kind;
    logic [63:0] base, opnd, old, newv, mis, got;
    hit = ins[31] && ins[29:27] == 3'b111 && !ins[26] && ins[25:22] == 4'b0 && ins[21] &&
          !ins[15] && ins[14:12] == 3'b111 && ins[11:10] == 2'b00;
    dw = ins[30];
    rs = int'(ins[20:16]); rn = int'(ins[9:5]); rt = int'(ins[4:0]);
    base = (rn == 31) ? sp_val : regs[rn];
    opnd = (rs == 31) ? 64'd0 : regs[rs];
    if (rn == 31) mis = base & 64'hF;
    else mis = base & (dw ? 64'h7 : 64'h3);
    kind = !hit ? 2 : (mis != 0 ? 1 : 0);
    old = rd_mem(base);
    if (!dw) begin old = {32'd0, old[31:0]}; opnd = {32'd0, opnd[31:0]}; end
    newv = (old < opnd) ? old : opnd;
    n_rd = 0; n_wr = 0;

    @(negedge clk);
    check(instr_ready, "R10 ready when idle", 64'(instr_ready), 64'd1);
    instr = ins; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check(!instr_ready, "R10 not ready while busy", 64'(instr_ready), 64'd0);
    for (int i = 0; i < 200; i++) begin
      if (done || fault || reject) break;
      @(negedge clk);
    end
    if (kind == 2) begin
      check(reject && !fault && !done, "R1 reject pulse", {61'd0, reject, fault, done}, 64'd4);
      check(n_rd + n_wr == 0, "R1 no memory access", 64'(n_rd + n_wr), 64'd0);
    end else if (kind == 1) begin
      check(fault && !reject && !done, (rn == 31) ? "R7 sp fault" : "R8 alignment fault",
            {61'd0, reject, fault, done}, 64'd2);
      check(n_rd + n_wr == 0, "R7 no memory access on fault", 64'(n_rd + n_wr), 64'd0);
    end else begin
      check(done && !fault && !reject, "R10 done pulse", {61'd0, reject, fault, done}, 64'd1);
      check(n_rd == 1 && n_wr == 1, "R9 one read and one write", 64'(n_rd * 16 + n_wr), 64'h11);
      check(last_raddr == base && last_waddr == base, (rn == 31) ? "R7 sp base address" : "R2 base address",
            last_raddr, base);
      check(last_rdw == dw, "R3 access size", 64'(last_rdw), 64'(dw));
      got = rd_mem(base);
      if (!dw) got = {32'd0, got[31:0]};
      check(got == newv, (rs == 31) ? "R2 zero operand min" : "R4 stored minimum", got, newv);
      check(rd_we == (rt != 31), "R6 write enable", 64'(rd_we), 64'(rt != 31));
      if (rt != 31) begin
        check(rd_idx == 5'(rt), "R6 destination index", 64'(rd_idx), 64'(rt));
        check(rd_data == old, "R5 original value zero-extended", rd_data, old);
        regs[rt] = rd_data;
      end
    end
    @(negedge clk);
    check(!done && !fault && !reject && instr_ready, "R10 single-cycle outputs",
          {60'd0, instr_ready, done, fault, reject}, 64'h8);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 4))
      0: return 64'd0;
      1: return '1;
      2: return 64'd1;
      3: return 64'h8000_0000_0000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'hDEAD_BEEF_0BAD_F00D + 64'(i);
    repeat (4) @(negedge clk);
    check(instr_ready && !done && !mem_req && !fault && !reject, "R10 reset state",
          {59'd0, instr_ready, done, mem_req, fault, reject}, 64'h10);
    rst_n = 1'b1;

    // R4 word, loaded greater than operand
    regs[1] = 64'h100; regs[2] = 64'h0000_0000_0000_0005; mem[64'h100] = 64'hFFFF_0000_0000_0900;
    run_op(enc(0, 2, 1, 3));
    // R4 word, loaded smaller
    regs[2] = 64'h7777; mem[64'h100] = 64'h1234_5678_0000_0042;
    run_op(enc(0, 2, 1, 4));
    // R9 equal operands still write
    regs[2] = 64'h42; run_op(enc(0, 2, 1, 5));
    // R3 upper bits of memory and operand ignored in word mode
    regs[1] = 64'h200; regs[2] = 64'hFFFF_FFFF_0000_0000; mem[64'h200] = 64'h0000_0001_FFFF_FFFF;
    run_op(enc(0, 2, 1, 6));
    // 64-bit: all-ones memory vs one
    regs[1] = 64'h300; regs[2] = 64'd1; mem[64'h300] = '1;
    run_op(enc(1, 2, 1, 7));
    // R2 operand index 31 reads zero
    regs[1] = 64'h308; mem[64'h308] = 64'h55; run_op(enc(1, 31, 1, 8));
    // R6 destination 31 suppressed
    regs[1] = 64'h310; regs[2] = 64'h9; run_op(enc(1, 2, 1, 31));
    // R7 stack pointer base, aligned
    sp_val = 64'h1000; regs[2] = 64'h3; run_op(enc(1, 2, 31, 9));
    // R7 stack pointer 8-aligned but not 16-aligned
    sp_val = 64'h1008; run_op(enc(1, 2, 31, 9));
    sp_val = 64'h1004; run_op(enc(0, 2, 31, 9));
    // R8 general base misaligned
    regs[1] = 64'h402; run_op(enc(0, 2, 1, 10));
    regs[1] = 64'h404; run_op(enc(1, 2, 1, 10));
    regs[1] = 64'h404; run_op(enc(0, 2, 1, 10));
    // R1 reject variants
    run_op(enc(0, 2, 1, 3) | 32'h0000_8000);
    run_op(enc(0, 2, 1, 3) & ~32'h0020_0000);
    run_op(enc(0, 2, 1, 3) & ~32'h8000_0000);
    run_op(enc(1, 2, 1, 3) | 32'h0080_0000);
    run_op(enc(0, 2, 1, 3) | 32'h0000_1000 ^ 32'h0000_1000 | 32'h0000_0400);
    // random mix
    for (int k = 0; k < 60; k++) begin
      int rs, rn, rt;
      bit dw;
      logic [63:0] a;
      dw = 1'($urandom_range(0, 1));
      rs = $urandom_range(1, 31); rn = $urandom_range(10, 20); rt = $urandom_range(0, 31);
      a = 64'($urandom_range(0, 15)) << 3;
      if (!dw && $urandom_range(0, 1) == 1) a = a + 64'd4;
      regs[rn] = a;
      if (rs != rn && rs != 31) regs[rs] = pick();
      if ($urandom_range(0, 3) == 0) mem[a] = pick();
      run_op(enc(dw, rs, rn, rt));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule